// File: doc/BRIEF.md
# Zero-Padded Convolutional Parity Code Generator

This block turns a serial run of k information bits into a systematic channel codeword. Each accepted bit, followed by Li zero bits that the block inserts on its own, is pushed through two feed-forward shift-register branches. Each branch has its own programmable tap vector and yields one parity bit for every position. The zeros themselves are never sent, but the parity they cause is. Adding zeros therefore stretches the codeword and lowers the rate without changing the data length.

The output is a single serial stream with a valid/ready handshake. For each input position, the parity bit of branch A is followed by the parity bit of branch B. After the parity of all k+Li positions, the k information bits follow in arrival order. The block keeps these bits in an internal store while the parity is sent. A start pulse captures the configuration (k, Li and both tap vectors) and clears both shift registers, so every codeword begins from the all-zero state. Back-pressure on the output stalls generation without losing a bit.

Top module: `zp_conv_coder`

## Requirements
- R1: For input position t, a branch's parity bit is the XOR over i of tap[i] AND u(t-i), where tap bit 0 weighs the current input, bit i weighs the input i positions earlier, and positions before the first data bit count as zero.
- R2: For each position, the branch A parity bit is emitted first and the branch B parity bit second, and positions follow in increasing order.
- R3: After the k data bits, the block feeds Li zero bits through both branches and emits their 2*Li parity bits. The zero bits themselves never appear on the output.
- R4: After all parity bits, the k information bits are emitted in the order they were accepted.
- R5: A codeword has exactly 2*(k+Li)+k bits, and code_last is high on its final bit only. For example, k=12 and Li=6 give 48 bits, and k=12 and Li=0 give 36 bits.
- R6: A start pulse taken while idle clears both shift registers and latches cfg_k, cfg_pad, cfg_tap_a and cfg_tap_b, so a codeword does not depend on any earlier one.
- R7: in_ready is high only while fewer than k data bits of the current codeword have been accepted. It stays low while idle, during padding and while information bits are sent.
- R8: While code_valid is high and code_ready is low, code_valid, code_data and code_last hold their values in the next cycle, and no bit is dropped or repeated.
- R9: A start pulse or a change of the configuration inputs while a codeword is in progress has no effect on that codeword.
- R10: While reset is asserted and after its release, code_valid and in_ready are low until a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that opens a codeword while idle |
| cfg_k | input | 7 | Number of information bits, 1 to K_MAX |
| cfg_pad | input | 7 | Number of zero padding positions, 0 to PAD_MAX |
| cfg_tap_a | input | 16 | Branch A taps, bit i weighs the input i positions back |
| cfg_tap_b | input | 16 | Branch B taps, same bit order |
| in_valid | input | 1 | Information bit on in_data is offered |
| in_ready | output | 1 | Block takes an information bit this cycle |
| in_data | input | 1 | Serial information bit |
| code_valid | output | 1 | code_data holds a codeword bit |
| code_ready | input | 1 | Consumer takes the codeword bit |
| code_data | output | 1 | Serial codeword bit |
| code_last | output | 1 | Marks the final codeword bit |

## Verification
Two events can fall in the same cycle: the branch B parity bit of one position leaves the block while the next information bit is taken in, which refills the pending parity pair at once. The bench provokes this by holding in_valid and code_ready high through whole codewords, and also by throttling both sides with independent pseudo-random patterns so that the refill meets stalls in every phase. It judges the result by comparing each emitted bit with a codeword it computes arithmetically from the taps and data. It also counts any handshake accepted beyond k data bits and any output bit that changes during a stall.

// File: rtl/zpc_pkg.sv
package zpc_pkg;

  // Sequencing phases of one codeword
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_PAD  = 2'd2,
    PH_INFO = 2'd3
  } phase_e;

endpackage

// File: rtl/zpc_branch.sv
module zpc_branch #(
  parameter int TAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [TAP_W-1:0] cfg_taps,
  output logic             parity
);

  localparam int HW = TAP_W - 1;

  logic [HW-1:0]    hist_q, hist_d;
  logic [TAP_W-1:0] taps_q, taps_d;

  // Window: bit 0 is the current input, bit i the input i positions back
  assign parity = ^(taps_q & {hist_q, bit_in});

  always_comb begin
    hist_d = hist_q;
    taps_d = taps_q;
    if (clr) begin
      hist_d = '0;
      taps_d = cfg_taps;
    end else if (shift_en) begin
      hist_d = HW'({hist_q, bit_in});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      taps_q <= '0;
    end else begin
      hist_q <= hist_d;
      taps_q <= taps_d;
    end
  end

  // R6: a clear leaves an all-zero history
  p_clear_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hist_q == '0));

  // R1: the newest history bit is the input shifted in on the previous cycle
  p_shift_newest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (hist_q[0] == $past(bit_in)));

endmodule

// File: rtl/zpc_info_store.sv
module zpc_info_store #(
  parameter int K_MAX = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [K_MAX-1:0] mem_q, mem_d;

  assign rd_bit = mem_q[rd_idx];

  always_comb begin
    mem_d = mem_q;
    if (wr_en) begin
      mem_d[wr_idx] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  // R4: a stored bit reads back at its own index on the next cycle
  p_store_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == rd_idx)) |=> (rd_bit == $past(wr_bit)));

endmodule

// File: rtl/zpc_sequencer.sv
module zpc_sequencer
  import zpc_pkg::*;
#(
  parameter int K_MAX   = 64,
  parameter int PAD_MAX = 64,
  parameter int KW      = 7,
  parameter int PW      = 7,
  parameter int POS_W   = 8,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KW-1:0]    cfg_k,
  input  logic [PW-1:0]    cfg_pad,
  input  logic             in_valid,
  input  logic             in_data,
  output logic             in_ready,
  input  logic             par_a,
  input  logic             par_b,
  output logic             clr,
  output logic             shift_en,
  output logic             feed_bit,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_bit,
  input  logic             code_ready,
  output logic             code_valid,
  output logic             code_data,
  output logic             code_last
);

  phase_e           phase_q, phase_d;
  logic [KW-1:0]    k_q, k_d;
  logic [PW-1:0]    pad_q, pad_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [IDX_W-1:0] rd_q, rd_d;
  logic             pend_q, pend_d;
  logic             selb_q, selb_d;
  logic             pa_q, pa_d;
  logic             pb_q, pb_d;

  logic             slot_free;
  logic             gen_data, gen_pad, gen;
  logic [POS_W-1:0] k_ext, span_ext;
  logic             info_turn, info_end, info_fire;

  // Pending parity pair frees its slot when empty or when its B bit leaves
  assign slot_free = !pend_q || (selb_q && code_ready);
  assign in_ready  = (phase_q == PH_DATA) && slot_free;
  assign gen_data  = in_ready && in_valid;
  assign gen_pad   = (phase_q == PH_PAD) && slot_free;
  assign gen       = gen_data || gen_pad;

  assign k_ext    = POS_W'(k_q);
  assign span_ext = POS_W'(k_q) + POS_W'(pad_q);

  assign info_turn = (phase_q == PH_INFO) && !pend_q;
  assign info_end  = (KW'(rd_q) == (k_q - KW'(1)));
  assign info_fire = info_turn && code_ready;

  assign clr      = (phase_q == PH_IDLE) && start;
  assign shift_en = gen;
  assign feed_bit = (phase_q == PH_DATA) ? in_data : 1'b0;
  assign wr_en    = gen_data;
  assign wr_idx   = IDX_W'(pos_q);
  assign rd_idx   = rd_q;

  assign code_valid = pend_q || (phase_q == PH_INFO);
  assign code_data  = pend_q ? (selb_q ? pb_q : pa_q) : rd_bit;
  assign code_last  = info_turn && info_end;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    k_d     = k_q;
    pad_d   = pad_q;
    pos_d   = pos_q;
    rd_d    = rd_q;
    pend_d  = pend_q;
    selb_d  = selb_q;
    pa_d    = pa_q;
    pb_d    = pb_q;

    if (gen) begin
      pend_d = 1'b1;
      selb_d = 1'b0;
      pa_d   = par_a;
      pb_d   = par_b;
      pos_d  = pos_q + POS_W'(1);
    end else if (pend_q && code_ready) begin
      if (selb_q) begin
        pend_d = 1'b0;
      end else begin
        selb_d = 1'b1;
      end
    end

    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          k_d     = cfg_k;
          pad_d   = cfg_pad;
          pos_d   = '0;
          rd_d    = '0;
          phase_d = PH_DATA;
        end
      end
      PH_DATA: begin
        if (gen_data && (pos_q == k_ext - POS_W'(1))) begin
          phase_d = (pad_q == '0) ? PH_INFO : PH_PAD;
        end
      end
      PH_PAD: begin
        if (gen_pad && (pos_q == span_ext - POS_W'(1))) begin
          phase_d = PH_INFO;
        end
      end
      PH_INFO: begin
        if (info_fire) begin
          rd_d = rd_q + IDX_W'(1);
          if (info_end) begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      k_q     <= '0;
      pad_q   <= '0;
      pos_q   <= '0;
      rd_q    <= '0;
      pend_q  <= 1'b0;
      selb_q  <= 1'b0;
      pa_q    <= 1'b0;
      pb_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      k_q     <= k_d;
      pad_q   <= pad_d;
      pos_q   <= pos_d;
      rd_q    <= rd_d;
      pend_q  <= pend_d;
      selb_q  <= selb_d;
      pa_q    <= pa_d;
      pb_q    <= pb_d;
    end
  end

  // R8: a stalled output bit holds until taken
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready) |=>
      (code_valid && $stable(code_data) && $stable(code_last)));

  // R5: the end marker only travels with a valid bit
  p_last_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    code_last |-> code_valid);

  // R5: after the final bit is taken the block falls silent
  p_quiet_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_ready && code_last) |=> (!code_valid && !in_ready));

  // R7: no input is taken once k bits have been counted
  p_ready_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (pos_q < k_ext));

  // R4: information read index stays inside the captured length
  p_info_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    info_turn |-> (KW'(rd_q) < k_q));

endmodule

// File: rtl/zp_conv_coder.sv
module zp_conv_coder #(
  parameter int TAP_W   = 16,
  parameter int K_MAX   = 64,
  parameter int PAD_MAX = 64,
  localparam int KW     = $clog2(K_MAX + 1),
  localparam int PW     = $clog2(PAD_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KW-1:0]    cfg_k,
  input  logic [PW-1:0]    cfg_pad,
  input  logic [TAP_W-1:0] cfg_tap_a,
  input  logic [TAP_W-1:0] cfg_tap_b,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_data,
  output logic             code_valid,
  input  logic             code_ready,
  output logic             code_data,
  output logic             code_last
);

  localparam int POS_W    = $clog2(K_MAX + PAD_MAX + 1);
  localparam int IDX_W    = (K_MAX > 1) ? $clog2(K_MAX) : 1;
  localparam int BRANCHES = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic             clr, shift_en, feed_bit;
  logic             wr_en, rd_bit;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [TAP_W-1:0] tap_cfg [BRANCHES];
  logic             par     [BRANCHES];

  assign tap_cfg[0] = cfg_tap_a;
  assign tap_cfg[1] = cfg_tap_b;

  for (genvar gi = 0; gi < BRANCHES; gi++) begin : g_branch
    zpc_branch #(
      .TAP_W (TAP_W)
    ) u_branch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .clr      (clr),
      .shift_en (shift_en),
      .bit_in   (feed_bit),
      .cfg_taps (tap_cfg[gi]),
      .parity   (par[gi])
    );
  end

  zpc_info_store #(
    .K_MAX (K_MAX),
    .IDX_W (IDX_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_bit (in_data),
    .rd_idx (rd_idx),
    .rd_bit (rd_bit)
  );

  zpc_sequencer #(
    .K_MAX   (K_MAX),
    .PAD_MAX (PAD_MAX),
    .KW      (KW),
    .PW      (PW),
    .POS_W   (POS_W),
    .IDX_W   (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .cfg_k      (cfg_k),
    .cfg_pad    (cfg_pad),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .par_a      (par[0]),
    .par_b      (par[1]),
    .clr        (clr),
    .shift_en   (shift_en),
    .feed_bit   (feed_bit),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .rd_bit     (rd_bit),
    .code_ready (code_ready),
    .code_valid (code_valid),
    .code_data  (code_data),
    .code_last  (code_last)
  );

  // R10: nothing is offered or requested while reset is held
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_int_n |-> (!code_valid && !in_ready));

endmodule

// File: tb/zp_conv_coder_tb_top.sv
module zp_conv_coder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [6:0]  cfg_k, cfg_pad;
  logic [15:0] cfg_tap_a, cfg_tap_b;
  logic        in_valid, in_ready, in_data;
  logic        code_valid, code_ready, code_data, code_last;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          cycles   = 0;
  bit          finished = 1'b0;
  logic [15:0] lfsr     = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zp_conv_coder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_k      (cfg_k),
    .cfg_pad    (cfg_pad),
    .cfg_tap_a  (cfg_tap_a),
    .cfg_tap_b  (cfg_tap_b),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code_data  (code_data),
    .code_last  (code_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // One codeword: build the expected stream, drive, collect, judge
  task automatic run_cw(input int k, input int pad, input logic [15:0] ta,
                        input logic [15:0] tb, input logic [63:0] data,
                        input int mode, input bit poke);
    logic exp_b [0:319];
    int   total;
    int   sent, extra, got, cyc;
    int   mis_d, mis_p, mis_i, last_bad, stall_bad;
    bit   done, prev_stall, prev_data, prev_last;
    logic first0, first1;
    total = 2 * (k + pad) + k;
    for (int t = 0; t < k + pad; t++) begin
      logic pa, pb, u;
      pa = 1'b0;
      pb = 1'b0;
      for (int i = 0; i < 16; i++) begin
        if (t - i >= 0) begin
          u  = (t - i < k) ? data[t-i] : 1'b0;
          pa = pa ^ (ta[i] & u);
          pb = pb ^ (tb[i] & u);
        end
      end
      exp_b[2*t]   = pa;
      exp_b[2*t+1] = pb;
    end
    for (int j = 0; j < k; j++) exp_b[2*(k+pad)+j] = data[j];

    @(negedge clk);
    cfg_k = 7'(k); cfg_pad = 7'(pad); cfg_tap_a = ta; cfg_tap_b = tb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    sent = 0; extra = 0; got = 0; cyc = 0;
    mis_d = 0; mis_p = 0; mis_i = 0; last_bad = 0; stall_bad = 0;
    done = 1'b0; prev_stall = 1'b0; prev_data = 1'b0; prev_last = 1'b0;
    first0 = 1'bx; first1 = 1'bx;
    while (!done && cyc < RUN_LIMIT) begin
      logic vld;
      step_lfsr();
      code_ready = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      vld        = (mode == 0) ? 1'b1 : (lfsr[5] | lfsr[9]);
      if (sent < k) begin
        in_valid = vld; in_data = data[sent];
      end else begin
        in_valid = 1'b1; in_data = 1'b1;
      end
      start = poke && (cyc == 6 || cyc == 40);
      if (start) begin
        cfg_k = 7'd1; cfg_pad = 7'd0; cfg_tap_a = 16'h0; cfg_tap_b = 16'h0;
      end else begin
        cfg_k = 7'(k); cfg_pad = 7'(pad); cfg_tap_a = ta; cfg_tap_b = tb;
      end
      #1;
      if (prev_stall && (!code_valid || code_data !== prev_data || code_last !== prev_last))
        stall_bad++;
      if (in_valid && in_ready) begin
        if (sent < k) sent++;
        else extra++;
      end
      if (code_valid && code_ready) begin
        if (got < total) begin
          if (got == 0) first0 = code_data;
          if (got == 1) first1 = code_data;
          if (code_data !== exp_b[got]) begin
            if (got < 2 * k) mis_d++;
            else if (got < 2 * (k + pad)) mis_p++;
            else mis_i++;
          end
        end
        if (code_last !== (got == total - 1)) last_bad++;
        if (code_last) done = 1'b1;
        got++;
      end
      prev_stall = code_valid && !code_ready;
      prev_data  = code_data;
      prev_last  = code_last;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0; in_data = 1'b0; code_ready = 1'b1;
    #1;
    if (cyc >= RUN_LIMIT) chk(1'b0, "run watchdog", cyc, RUN_LIMIT);
    chk(mis_d == 0, "R1_R2 data parity bits", mis_d, 0);
    chk(mis_p == 0, "R3 padding parity bits", mis_p, 0);
    chk(mis_i == 0, "R4 appended information bits", mis_i, 0);
    chk(got == total, "R5 codeword length", got, total);
    chk(last_bad == 0, "R5 last flag placement", last_bad, 0);
    chk({first0, first1} === {exp_b[0], exp_b[1]}, "R6 first pair from cleared state",
        int'({first0, first1}), int'({exp_b[0], exp_b[1]}));
    chk(extra == 0, "R7 inputs taken beyond k", extra, 0);
    chk(stall_bad == 0, "R8 output held under stall", stall_bad, 0);
    chk(!code_valid && !in_ready, "R7 idle after codeword", int'({code_valid, in_ready}), 0);
    if (poke)
      chk(mis_d + mis_p + mis_i == 0 && got == total, "R9 start ignored while busy",
          mis_d + mis_p + mis_i, 0);
  endtask

  initial begin
    logic [15:0] tap_a_set [3];
    logic [15:0] tap_b_set [3];
    int          k_set   [5];
    int          pad_set [4];
    tap_a_set = '{16'h0069, 16'h0029, 16'hFFFF};
    tap_b_set = '{16'h0043, 16'h0C83, 16'h8001};
    k_set     = '{1, 2, 5, 12, 64};
    pad_set   = '{0, 1, 6, 64};

    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = 1'b0; code_ready = 1'b0;
    cfg_k = 7'd0; cfg_pad = 7'd0; cfg_tap_a = 16'h0; cfg_tap_b = 16'h0;
    repeat (3) @(negedge clk);
    chk(!code_valid && !in_ready, "R10 outputs low in reset", int'({code_valid, in_ready}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!code_valid && !in_ready, "R10 idle after reset release", int'({code_valid, in_ready}), 0);

    // Worked configurations: 48-bit and 36-bit codewords
    run_cw(12, 6, 16'h0069, 16'h0043, 64'h0000_0000_0000_0B5D, 0, 1'b0);
    run_cw(12, 0, 16'h0029, 16'h0C83, 64'h0000_0000_0000_0A37, 1, 1'b0);

    // R6: all-ones history followed by an all-zero codeword
    run_cw(5, 0, 16'hFFFF, 16'hFFFF, 64'h1F, 0, 1'b0);
    run_cw(1, 3, 16'hFFFF, 16'hFFFF, 64'h0, 0, 1'b0);

    // R9: start pulses and garbage configuration mid-codeword
    run_cw(12, 6, 16'h0069, 16'h0043, 64'h0000_0000_0000_0C3A, 1, 1'b1);
    run_cw(20, 4, 16'hFFFF, 16'h8001, 64'h0000_0000_000F_0F0F, 0, 1'b1);

    // Sweep over lengths, padding, tap sets and flow patterns
    foreach (k_set[ki]) begin
      foreach (pad_set[pi]) begin
        for (int ts = 0; ts < 3; ts++) begin
          for (int md = 0; md < 2; md++) begin
            logic [63:0] d;
            d = {$urandom(), $urandom()};
            run_cw(k_set[ki], pad_set[pi], tap_a_set[ts], tap_b_set[ts], d, md, 1'b0);
          end
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule